// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block decides where a 64-bit RISC core fetches next. Each instruction is a fixed 32 bits wide, while the program counter and the data registers are 64 bits wide. The block takes the current PC, the fetched instruction word and the first source register value, which has already been read. In the same cycle it produces the following PC. It also produces a request to write a return address into the link register.

The block covers five kinds of control flow:
- ordinary sequential flow;
- PC-relative conditional branches that compare one register against zero;
- region jumps that splice a 26-bit target into the low PC bits, with no addition;
- jump-and-link;
- register-indirect jumps, used for returns and dispatch through a pointer.

Opcodes with no assigned meaning are flagged as illegal, and execution continues sequentially. The computation is purely combinational. An optional register holds the selected PC so that the fetch stage can use it directly.

Top module: `npc_unit`

## Requirements
- R1: The opcode is `instr_i[31:26]`. Opcode 0x00 and opcodes 0x09 to 0x2F are ordinary instructions. For these, `next_pc_o` is `pc_i + 4`, `link_we_o` is 0 and `illegal_o` is 0.
- R2: For the region jump (opcode 0x02), `next_pc_o` is `{S[63:28], instr_i[25:0], 2'b00}`, where S is `pc_i + 4`. The upper 36 bits therefore come from S unchanged, and no offset is added.
- R3: When a conditional branch is taken, `next_pc_o` is `pc_i + 4` plus the sign-extended `instr_i[15:0]` shifted left by 2. When it is not taken, `next_pc_o` is `pc_i + 4`. The field `instr_i[20:16]` has no effect on a branch.
- R4: The branch conditions on `rs_i` are as follows:
  - opcode 0x04 is taken when `rs_i` equals zero;
  - opcode 0x05 is taken when `rs_i` is non-zero;
  - opcode 0x06 is taken when `rs_i` is negative in two's complement;
  - opcode 0x07 is taken when `rs_i` is zero or positive.
- R5: Jump-and-link (opcode 0x03) computes its target as in R2. It sets `link_we_o` to 1, `link_addr_o` to 31 and `link_val_o` to `pc_i + 4`.
- R6: For the register jump (opcode 0x01), `next_pc_o` is `{rs_i[63:2], 2'b00}` and `link_we_o` is 0.
- R7: For the register jump-and-link (opcode 0x08), the target is computed as in R6. The link outputs are the same as in R5.
- R8: Opcodes 0x30 to 0x3F set `illegal_o` to 1, give a `next_pc_o` of `pc_i + 4`, and keep `link_we_o` at 0.
- R9: While `rst_n` is low, `pc_q_o` equals `RESET_PC`. After reset, every rising clock edge loads `next_pc_o` into `pc_q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the PC register and the assertions |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 64 | PC of the current instruction |
| instr_i | input | 32 | Fetched instruction word |
| rs_i | input | 64 | First source register value |
| next_pc_o | output | 64 | Selected following PC |
| link_we_o | output | 1 | Request to write the return address |
| link_addr_o | output | 5 | Index of the register that receives the return address |
| link_val_o | output | 64 | Return address, `pc_i + 4` |
| illegal_o | output | 1 | Unassigned opcode seen |
| pc_q_o | output | 64 | Registered PC |

## Verification
The assertions check the following on every cycle:
- jumps always keep the upper 36 bits of `pc_i + 4` and produce word-aligned targets;
- branches that are not taken and unassigned opcodes fall through to `pc_i + 4`;
- a link write always targets register 31;
- the PC register always follows the previous cycle's selection.

Only the bench scenarios can show the exact targets: the sign of the branch offset at its extremes, a jump whose `pc_i + 4` crosses into a new 256 MB region, the largest target field, and the rule that the `rt` field has no effect on branches.

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int XLEN = 64,
  parameter int ILEN = 32,
  parameter int OPW = 6,
  parameter int TGTW = 26,
  parameter int IMMW = 16,
  parameter int REGW = 5,
  parameter int LINK_REG = 31,
  parameter bit REG_PC = 1'b1,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [ILEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  rs_i,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             link_we_o,
  output logic [REGW-1:0]  link_addr_o,
  output logic [XLEN-1:0]  link_val_o,
  output logic             illegal_o,
  output logic [XLEN-1:0]  pc_q_o
);

  localparam int STEP = ILEN / 8;
  localparam int ALN  = $clog2(STEP);
  localparam int HIW  = XLEN - TGTW - ALN;
  localparam int SXW  = XLEN - IMMW - ALN;

  localparam logic [OPW-1:0] OP_ALU   = 6'h00;
  localparam logic [OPW-1:0] OP_JR    = 6'h01;
  localparam logic [OPW-1:0] OP_J     = 6'h02;
  localparam logic [OPW-1:0] OP_JAL   = 6'h03;
  localparam logic [OPW-1:0] OP_BEQZ  = 6'h04;
  localparam logic [OPW-1:0] OP_BNEZ  = 6'h05;
  localparam logic [OPW-1:0] OP_BLTZ  = 6'h06;
  localparam logic [OPW-1:0] OP_BGEZ  = 6'h07;
  localparam logic [OPW-1:0] OP_JALR  = 6'h08;
  localparam logic [OPW-1:0] OP_LEGAL = 6'h2F;

  logic [OPW-1:0]  op;
  logic [TGTW-1:0] tgt;
  logic [IMMW-1:0] imm;
  logic [XLEN-1:0] pc_seq, jmp_tgt, br_tgt, reg_tgt;
  logic            rs_zero, rs_neg, taken;

  assign op      = instr_i[ILEN-1 -: OPW];
  assign tgt     = instr_i[TGTW-1:0];
  assign imm     = instr_i[IMMW-1:0];
  assign pc_seq  = pc_i + XLEN'(STEP);
  assign jmp_tgt = {pc_seq[XLEN-1 -: HIW], tgt, {ALN{1'b0}}};
  assign br_tgt  = pc_seq + {{SXW{imm[IMMW-1]}}, imm, {ALN{1'b0}}};
  assign reg_tgt = {rs_i[XLEN-1:ALN], {ALN{1'b0}}};
  assign rs_zero = (rs_i == '0);
  assign rs_neg  = rs_i[XLEN-1];

  always_comb begin
    unique case (op)
      OP_BEQZ: taken = rs_zero;
      OP_BNEZ: taken = !rs_zero;
      OP_BLTZ: taken = rs_neg;
      OP_BGEZ: taken = !rs_neg;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    next_pc_o = pc_seq;
    link_we_o = 1'b0;
    illegal_o = 1'b0;
    case (op)
      OP_J:                          next_pc_o = jmp_tgt;
      OP_JAL:  begin                 next_pc_o = jmp_tgt; link_we_o = 1'b1; end
      OP_JR:                         next_pc_o = reg_tgt;
      OP_JALR: begin                 next_pc_o = reg_tgt; link_we_o = 1'b1; end
      OP_BEQZ, OP_BNEZ,
      OP_BLTZ, OP_BGEZ:              next_pc_o = taken ? br_tgt : pc_seq;
      default:                       illegal_o = (op > OP_LEGAL);
    endcase
  end

  assign link_addr_o = REGW'(LINK_REG);
  assign link_val_o  = pc_seq;

  generate
    if (REG_PC) begin : g_reg
      logic [XLEN-1:0] pc_q;
      always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= next_pc_o;
      end
      assign pc_q_o = pc_q;

      assert_pc_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pc_q_o == $past(next_pc_o));
    end else begin : g_comb
      assign pc_q_o = next_pc_o;
    end
  endgenerate

  assert_jump_upper_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_J || op == OP_JAL) |->
      (next_pc_o[XLEN-1 -: HIW] == (pc_i + XLEN'(STEP)) >> (XLEN - HIW)) &&
      (next_pc_o[ALN-1:0] == '0));

  assert_branch_fallthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_BEQZ && rs_i != '0) || (op == OP_BNEZ && rs_i == '0) ||
     (op == OP_BLTZ && !rs_i[XLEN-1]) || (op == OP_BGEZ && rs_i[XLEN-1]))
      |-> next_pc_o == pc_i + XLEN'(STEP));

  assert_link_to_ra_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (link_addr_o == REGW'(LINK_REG)) &&
                  (op == OP_JAL || op == OP_JALR));

  assert_illegal_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (next_pc_o == pc_i + XLEN'(STEP)) && !link_we_o);

  assert_indirect_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JR || op == OP_JALR) |->
      (next_pc_o[ALN-1:0] == '0) && (next_pc_o[XLEN-1:ALN] == rs_i[XLEN-1:ALN]));

endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pc_i = '0;
  logic [31:0] instr_i = '0;
  logic [63:0] rs_i = '0;
  logic [63:0] next_pc_o, link_val_o, pc_q_o;
  logic        link_we_o, illegal_o;
  logic [4:0]  link_addr_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .instr_i(instr_i), .rs_i(rs_i),
    .next_pc_o(next_pc_o), .link_we_o(link_we_o), .link_addr_o(link_addr_o),
    .link_val_o(link_val_o), .illegal_o(illegal_o), .pc_q_o(pc_q_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [63:0] pc;
    logic [31:0] ins;
    logic [63:0] rs;
    logic [63:0] npc;
    logic        we;
    logic        ill;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{4'd1, 64'h1000, 32'h0000_0000, 64'h0, 64'h1004, 1'b0, 1'b0},                          // R1 op 0x00
    '{4'd1, 64'h1000, 32'hBC00_0000, 64'h0, 64'h1004, 1'b0, 1'b0},                          // R1 op 0x2F
    '{4'd1, 64'h1000, 32'h2400_0000, 64'h0, 64'h1004, 1'b0, 1'b0},                          // R1 op 0x09
    '{4'd2, 64'hABCD_0000_1234_5670, 32'h0800_0010, 64'h0, 64'hABCD_0000_1000_0040, 1'b0, 1'b0}, // R2 upper kept
    '{4'd2, 64'h0FFF_FFFC, 32'h0800_0001, 64'h0, 64'h1000_0004, 1'b0, 1'b0},                // R2 region crossing
    '{4'd2, 64'h0, 32'h0BFF_FFFF, 64'h0, 64'h0FFF_FFFC, 1'b0, 1'b0},                        // R2 max target
    '{4'd3, 64'h1000, 32'h101F_0010, 64'h0, 64'h1044, 1'b0, 1'b0},                          // R3 beqz taken, rt ignored
    '{4'd4, 64'h1000, 32'h1000_0010, 64'h5, 64'h1004, 1'b0, 1'b0},                          // R4 beqz not taken
    '{4'd3, 64'h1000, 32'h1400_FFFF, 64'h1, 64'h1000, 1'b0, 1'b0},                          // R3 bnez back by one
    '{4'd4, 64'h1000, 32'h1400_FFFF, 64'h0, 64'h1004, 1'b0, 1'b0},                          // R4 bnez not taken
    '{4'd3, 64'h10_0000, 32'h1800_8000, 64'h8000_0000_0000_0000, 64'hE_0004, 1'b0, 1'b0},  // R3 most negative offset
    '{4'd4, 64'h10_0000, 32'h1800_8000, 64'h0, 64'h10_0004, 1'b0, 1'b0},                    // R4 bltz zero not taken
    '{4'd3, 64'h0, 32'h1C00_7FFF, 64'h0, 64'h2_0000, 1'b0, 1'b0},                           // R3 bgez max offset
    '{4'd4, 64'h0, 32'h1C00_7FFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h4, 1'b0, 1'b0},              // R4 bgez negative
    '{4'd5, 64'h2000, 32'h0C00_0100, 64'h0, 64'h400, 1'b1, 1'b0},                           // R5 jal
    '{4'd6, 64'h1000, 32'h0400_0000, 64'h0000_1234_5678_9ABF, 64'h0000_1234_5678_9ABC, 1'b0, 1'b0}, // R6 jr
    '{4'd7, 64'h3000, 32'h2000_0000, 64'h4000, 64'h4000, 1'b1, 1'b0},                       // R7 jalr
    '{4'd8, 64'h5000, 32'hC000_0000, 64'h0, 64'h5004, 1'b0, 1'b1},                          // R8 op 0x30
    '{4'd8, 64'h5000, 32'hFC00_0000, 64'h0, 64'h5004, 1'b0, 1'b1},                          // R8 op 0x3F
    '{4'd4, 64'h8, 32'h1800_0004, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1C, 1'b0, 1'b0}              // R4 bltz taken
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset pc_q", pc_q_o, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pc_i = VT[i].pc; instr_i = VT[i].ins; rs_i = VT[i].rs;
      #2;
      chk($sformatf("R%0d vec%0d next_pc", VT[i].req, i), next_pc_o, VT[i].npc);
      chk($sformatf("R%0d vec%0d link_we", VT[i].req, i), 64'(link_we_o), 64'(VT[i].we));
      chk($sformatf("R%0d vec%0d illegal", VT[i].req, i), 64'(illegal_o), 64'(VT[i].ill));
      if (VT[i].we) begin
        chk($sformatf("R5 vec%0d link_addr", i), 64'(link_addr_o), 64'd31);
        chk($sformatf("R5 vec%0d link_val", i), link_val_o, VT[i].pc + 64'd4);
      end
    end

    // R9: registered PC follows the selected PC, including a jump
    @(negedge clk);
    pc_i = 64'h1000; instr_i = 32'h0000_0000; rs_i = '0;
    @(posedge clk); #1;
    chk("R9 pc_q after seq", pc_q_o, 64'h1004);
    @(negedge clk);
    pc_i = pc_q_o; instr_i = 32'h0800_0200;
    @(posedge clk); #1;
    chk("R9 pc_q after jump", pc_q_o, 64'h800);
    @(negedge clk);
    pc_i = pc_q_o; instr_i = 32'h1000_FFFE; rs_i = '0;
    @(posedge clk); #1;
    chk("R9 pc_q after backward branch", pc_q_o, 64'h7FC);

    // R9: reset reasserted overrides the selection
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R9 pc_q reset again", pc_q_o, 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule